// File: doc/BRIEF.md
# Banked Internal Data RAM with Bit Addressing

This block holds the 128-byte on-chip data store of an 8-bit controller core. The core reaches it through several ports. A working-register port selects one of eight registers inside whichever of four banks the two bank-select bits name. A direct byte port covers the whole 8-bit data address space. A single-bit port reads, sets, clears or writes one bit. A stack port pushes and pops through a hardware stack pointer.

The lowest 32 bytes hold the four register banks. The 16 bytes at 20h–2Fh are also reachable bit by bit. The rest is plain storage. Any byte address or bit address in the upper half is not stored here. It goes out unchanged on a peripheral-register port, with the bit target already split into a byte address and a bit index.

All reads are combinational from the current contents. All writes take effect at the rising clock edge.

Top module: `iram_core`

## Requirements
- R1: While `rst_ni` is low and after it is released, every RAM byte reads 00h, `sp_o` is 07h and `stk_err_o` is low.
- R2: The register port reaches byte `8*bank_sel_i + idx`, both for the combinational read and for the write at the clock edge.
- R3: Direct addresses 00h–7Fh read and write the RAM byte at that address, so every register stays reachable whatever bank is selected.
- R4: For bit address b below 80h, `bit_rd_o` is bit (b mod 8) of byte 20h + (b div 8).
- R5: `bit_op_i` codes are 0 none, 1 set, 2 clear and 3 write `bit_val_i`. An internal bit operation changes only the target bit of its byte, in one cycle.
- R6: For bit address b of 80h or above, `sfr_bit_addr_o` is b with its low three bits cleared and `sfr_bit_idx_o` is b mod 8. Any operation code raises `sfr_bit_we_o` with the resolved value on `sfr_bit_val_o`. `bit_rd_o` follows `sfr_bit_rd_i`, and no RAM byte changes.
- R7: A direct address of 80h or above drives `sfr_we_o` for a write and returns `sfr_rd_data_i` for a read, and no RAM byte changes.
- R8: A push raises SP by one and writes the data at the new SP. `pop_data_o` shows the byte at SP, and a pop lowers SP by one at the edge.
- R9: A load of SP overrides push and pop, which then do nothing. When push and pop arrive together, the push is done and the pop is ignored. With no stack operation, SP holds its value.
- R10: SP wraps modulo 256. A push whose target is 80h or above writes nothing. A pop with SP at 80h or above returns 00h. Either case raises `stk_err_o` for the following cycle, and SP still moves.
- R11: When several writes hit one byte in the same cycle, the winner is the push, then the direct write, then the register write, then the bit operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bank_sel_i | input | 2 | Active register bank |
| reg_rd_idx_i | input | 3 | Register index for reading |
| reg_rd_data_o | output | 8 | Register read data |
| reg_we_i | input | 1 | Register write strobe |
| reg_wr_idx_i | input | 3 | Register index for writing |
| reg_wr_data_i | input | 8 | Register write data |
| dir_addr_i | input | 8 | Direct byte address |
| dir_rd_data_o | output | 8 | Direct read data |
| dir_we_i | input | 1 | Direct write strobe |
| dir_wr_data_i | input | 8 | Direct write data |
| bit_addr_i | input | 8 | Bit address |
| bit_op_i | input | 2 | Bit operation code |
| bit_val_i | input | 1 | Value for the bit write operation |
| bit_rd_o | output | 1 | Addressed bit value |
| push_i | input | 1 | Push request |
| push_data_i | input | 8 | Push data |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | 8 | Byte at the stack top |
| sp_load_i | input | 1 | Load the stack pointer |
| sp_load_val_i | input | 8 | New stack pointer value |
| sp_o | output | 8 | Current stack pointer |
| stk_err_o | output | 1 | Stack access left internal RAM in the previous cycle |
| sfr_addr_o | output | 8 | Peripheral byte address |
| sfr_we_o | output | 1 | Peripheral byte write strobe |
| sfr_wr_data_o | output | 8 | Peripheral byte write data |
| sfr_rd_data_i | input | 8 | Peripheral byte read data |
| sfr_bit_addr_o | output | 8 | Peripheral register holding the bit |
| sfr_bit_idx_o | output | 3 | Bit index in that register |
| sfr_bit_we_o | output | 1 | Peripheral bit write strobe |
| sfr_bit_val_o | output | 1 | Peripheral bit write value |
| sfr_bit_rd_i | input | 1 | Peripheral bit read value |

## Verification
The bench builds the block with its default parameters: 128 bytes, four banks of eight registers, a bit window at 20h, an 8-bit address and a stack pointer that resets to 07h. With these values the stack pointer can be loaded at the 7Fh/80h edge and at FFh, so a single push reaches both the out-of-range error and the wrap to 00h. Those cases are driven on purpose, alongside pushes that collide with direct, register and bit writes to the same byte.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [1:0] {
    BIT_NOP = 2'd0,
    BIT_SET = 2'd1,
    BIT_CLR = 2'd2,
    BIT_WR  = 2'd3
  } bit_op_e;
endpackage

// File: rtl/iram_bit_map.sv
module iram_bit_map #(
  parameter int AW = 8,
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  logic [AW-1:0] bit_addr_i,
  output logic          is_sfr_o,
  output logic [AW-1:0] ram_byte_o,
  output logic [AW-1:0] sfr_byte_o,
  output logic [2:0]    idx_o
);
  localparam int GW = AW - 4;  // byte-group bits inside the internal window

  logic [GW-1:0] grp;
  assign grp        = bit_addr_i[AW-2:3];
  assign is_sfr_o   = bit_addr_i[AW-1];
  assign ram_byte_o = BIT_BASE + AW'(grp);
  assign sfr_byte_o = {bit_addr_i[AW-1:3], 3'b000};
  assign idx_o      = bit_addr_i[2:0];
endmodule

// File: rtl/iram_stack.sv
module iram_stack #(
  parameter int AW = 8,
  parameter int RAM_BYTES = 128,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] push_addr_o,
  output logic          push_we_o,
  output logic          pop_ok_o,
  output logic          err_o
);
  localparam logic [AW:0] RAM_LIM = (AW+1)'(RAM_BYTES);

  logic [AW-1:0] sp_q, sp_d;
  logic          err_q, err_d;
  logic          push_eff, pop_eff, push_in;

  assign push_eff    = push_i & ~load_i;
  assign pop_eff     = pop_i & ~push_i & ~load_i;
  assign push_addr_o = sp_q + AW'(1);
  assign push_in     = {1'b0, push_addr_o} < RAM_LIM;
  assign pop_ok_o    = {1'b0, sp_q} < RAM_LIM;
  assign push_we_o   = push_eff & push_in;

  always_comb begin
    sp_d = sp_q;
    if (load_i)        sp_d = load_val_i;
    else if (push_eff) sp_d = push_addr_o;
    else if (pop_eff)  sp_d = sp_q - AW'(1);
    err_d = (push_eff & ~push_in) | (pop_eff & ~pop_ok_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= SP_RST;
      err_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      err_q <= err_d;
    end
  end

  assign sp_o  = sp_q;
  assign err_o = err_q;

  a_r8_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !load_i |=> sp_o == $past(sp_o) + AW'(1));
  a_r8_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !load_i |=> sp_o == $past(sp_o) - AW'(1));
  a_r9_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sp_o == $past(load_val_i));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i && !pop_i && !load_i |=> $stable(sp_o) && !err_o);
  a_r10_push_out_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !load_i && sp_o >= AW'(RAM_BYTES - 1) && sp_o != '1 |=> err_o);
endmodule

// File: rtl/iram_array.sv
module iram_array #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int RAM_BYTES = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_we_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          dir_we_i,
  input  logic [AW-1:0] dir_addr_i,
  input  logic [DW-1:0] dir_data_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_data_i,
  input  logic          bit_we_i,
  input  logic [AW-1:0] bit_byte_i,
  input  logic [2:0]    bit_idx_i,
  input  logic          bit_val_i,
  input  logic [AW-1:0] rd_dir_addr_i,
  output logic [DW-1:0] rd_dir_data_o,
  input  logic [AW-1:0] rd_reg_addr_i,
  output logic [DW-1:0] rd_reg_data_o,
  input  logic [AW-1:0] rd_bit_addr_i,
  output logic [DW-1:0] rd_bit_data_o,
  input  logic [AW-1:0] rd_pop_addr_i,
  output logic [DW-1:0] rd_pop_data_o
);
  localparam int IW = $clog2(RAM_BYTES);

  logic [DW-1:0] mem_q [RAM_BYTES];
  logic [DW-1:0] mem_d [RAM_BYTES];

  // later assignments override earlier ones: push > direct > register > bit
  always_comb begin
    for (int i = 0; i < RAM_BYTES; i++) begin
      mem_d[i] = mem_q[i];
      if (bit_we_i  && bit_byte_i  == AW'(i)) mem_d[i][bit_idx_i] = bit_val_i;
      if (reg_we_i  && reg_addr_i  == AW'(i)) mem_d[i] = reg_data_i;
      if (dir_we_i  && dir_addr_i  == AW'(i)) mem_d[i] = dir_data_i;
      if (push_we_i && push_addr_i == AW'(i)) mem_d[i] = push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RAM_BYTES; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < RAM_BYTES; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_dir_data_o = mem_q[rd_dir_addr_i[IW-1:0]];
  assign rd_reg_data_o = mem_q[rd_reg_addr_i[IW-1:0]];
  assign rd_bit_data_o = mem_q[rd_bit_addr_i[IW-1:0]];
  assign rd_pop_data_o = mem_q[rd_pop_addr_i[IW-1:0]];

  logic          bit_solo;
  logic [DW-1:0] bit_cur, bit_mask;
  assign bit_solo = bit_we_i
                  && !(push_we_i && push_addr_i == bit_byte_i)
                  && !(dir_we_i  && dir_addr_i  == bit_byte_i)
                  && !(reg_we_i  && reg_addr_i  == bit_byte_i);
  assign bit_cur  = mem_q[bit_byte_i[IW-1:0]];
  assign bit_mask = DW'(1) << bit_idx_i;

  a_r5_bit_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_solo |=> ((mem_q[$past(bit_byte_i[IW-1:0])] ^ $past(bit_cur)) & ~$past(bit_mask)) == '0);
  a_r5_bit_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_solo |=> mem_q[$past(bit_byte_i[IW-1:0])][$past(bit_idx_i)] == $past(bit_val_i));
  a_r11_push_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_we_i && dir_we_i && push_addr_i == dir_addr_i
    |=> mem_q[$past(push_addr_i[IW-1:0])] == $past(push_data_i));
endmodule

// File: rtl/iram_core.sv
module iram_core
  import iram_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int RAM_BYTES = 128,
  parameter int BANKS = 4,
  parameter int REGS = 8,
  parameter logic [AW-1:0] BIT_BASE = 8'h20,
  parameter logic [AW-1:0] SP_RST = 8'h07,
  localparam int BSW = $clog2(BANKS),
  localparam int RIW = $clog2(REGS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [BSW-1:0] bank_sel_i,
  input  logic [RIW-1:0] reg_rd_idx_i,
  output logic [DW-1:0]  reg_rd_data_o,
  input  logic           reg_we_i,
  input  logic [RIW-1:0] reg_wr_idx_i,
  input  logic [DW-1:0]  reg_wr_data_i,
  input  logic [AW-1:0]  dir_addr_i,
  output logic [DW-1:0]  dir_rd_data_o,
  input  logic           dir_we_i,
  input  logic [DW-1:0]  dir_wr_data_i,
  input  logic [AW-1:0]  bit_addr_i,
  input  logic [1:0]     bit_op_i,
  input  logic           bit_val_i,
  output logic           bit_rd_o,
  input  logic           push_i,
  input  logic [DW-1:0]  push_data_i,
  input  logic           pop_i,
  output logic [DW-1:0]  pop_data_o,
  input  logic           sp_load_i,
  input  logic [AW-1:0]  sp_load_val_i,
  output logic [AW-1:0]  sp_o,
  output logic           stk_err_o,
  output logic [AW-1:0]  sfr_addr_o,
  output logic           sfr_we_o,
  output logic [DW-1:0]  sfr_wr_data_o,
  input  logic [DW-1:0]  sfr_rd_data_i,
  output logic [AW-1:0]  sfr_bit_addr_o,
  output logic [2:0]     sfr_bit_idx_o,
  output logic           sfr_bit_we_o,
  output logic           sfr_bit_val_o,
  input  logic           sfr_bit_rd_i
);
  logic [AW-1:0] reg_rd_addr, reg_wr_addr;
  assign reg_rd_addr = AW'({bank_sel_i, reg_rd_idx_i});
  assign reg_wr_addr = AW'({bank_sel_i, reg_wr_idx_i});

  logic dir_int;
  assign dir_int = ~dir_addr_i[AW-1];

  // bit target decode
  logic          bit_sfr;
  logic [AW-1:0] bit_byte, bit_sfr_byte;
  logic [2:0]    bit_idx;
  iram_bit_map #(.AW(AW), .BIT_BASE(BIT_BASE)) u_map (
    .bit_addr_i (bit_addr_i),
    .is_sfr_o   (bit_sfr),
    .ram_byte_o (bit_byte),
    .sfr_byte_o (bit_sfr_byte),
    .idx_o      (bit_idx)
  );

  bit_op_e bit_op;
  logic    bit_act, bit_new;
  assign bit_op  = bit_op_e'(bit_op_i);
  assign bit_act = bit_op != BIT_NOP;
  always_comb begin
    unique case (bit_op)
      BIT_SET: bit_new = 1'b1;
      BIT_CLR: bit_new = 1'b0;
      BIT_WR:  bit_new = bit_val_i;
      default: bit_new = 1'b0;
    endcase
  end

  // stack pointer
  logic [AW-1:0] push_addr;
  logic          push_we, pop_ok;
  iram_stack #(.AW(AW), .RAM_BYTES(RAM_BYTES), .SP_RST(SP_RST)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .load_i      (sp_load_i),
    .load_val_i  (sp_load_val_i),
    .sp_o        (sp_o),
    .push_addr_o (push_addr),
    .push_we_o   (push_we),
    .pop_ok_o    (pop_ok),
    .err_o       (stk_err_o)
  );

  logic [DW-1:0] rd_dir, rd_reg, rd_bit, rd_pop;
  iram_array #(.DW(DW), .AW(AW), .RAM_BYTES(RAM_BYTES)) u_array (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .push_we_i     (push_we),
    .push_addr_i   (push_addr),
    .push_data_i   (push_data_i),
    .dir_we_i      (dir_we_i & dir_int),
    .dir_addr_i    (dir_addr_i),
    .dir_data_i    (dir_wr_data_i),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_wr_addr),
    .reg_data_i    (reg_wr_data_i),
    .bit_we_i      (bit_act & ~bit_sfr),
    .bit_byte_i    (bit_byte),
    .bit_idx_i     (bit_idx),
    .bit_val_i     (bit_new),
    .rd_dir_addr_i (dir_addr_i),
    .rd_dir_data_o (rd_dir),
    .rd_reg_addr_i (reg_rd_addr),
    .rd_reg_data_o (rd_reg),
    .rd_bit_addr_i (bit_byte),
    .rd_bit_data_o (rd_bit),
    .rd_pop_addr_i (sp_o),
    .rd_pop_data_o (rd_pop)
  );

  assign reg_rd_data_o = rd_reg;
  assign dir_rd_data_o = dir_int ? rd_dir : sfr_rd_data_i;
  assign bit_rd_o      = bit_sfr ? sfr_bit_rd_i : rd_bit[bit_idx];
  assign pop_data_o    = pop_ok ? rd_pop : '0;

  assign sfr_addr_o     = dir_addr_i;
  assign sfr_we_o       = dir_we_i & ~dir_int;
  assign sfr_wr_data_o  = dir_wr_data_i;
  assign sfr_bit_addr_o = bit_sfr_byte;
  assign sfr_bit_idx_o  = bit_idx;
  assign sfr_bit_we_o   = bit_act & bit_sfr;
  assign sfr_bit_val_o  = bit_new;

  a_r2_bank_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_addr_i == reg_rd_addr |-> reg_rd_data_o == dir_rd_data_o);
  a_r2_reg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !push_i && !pop_i && !sp_load_i && !dir_we_i && !bit_act
    && reg_rd_idx_i == reg_wr_idx_i && $stable(bank_sel_i)
    |=> $past(reg_rd_idx_i) != reg_rd_idx_i || $past(bank_sel_i) != bank_sel_i
        || reg_rd_data_o == $past(reg_wr_data_i));
endmodule

// File: tb/tb_iram_core.sv
module tb_iram_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] bank_sel_i;
  logic [2:0] reg_rd_idx_i, reg_wr_idx_i;
  logic [7:0] reg_rd_data_o, reg_wr_data_i;
  logic       reg_we_i;
  logic [7:0] dir_addr_i, dir_rd_data_o, dir_wr_data_i;
  logic       dir_we_i;
  logic [7:0] bit_addr_i;
  logic [1:0] bit_op_i;
  logic       bit_val_i, bit_rd_o;
  logic       push_i, pop_i, sp_load_i, stk_err_o;
  logic [7:0] push_data_i, pop_data_o, sp_load_val_i, sp_o;
  logic [7:0] sfr_addr_o, sfr_wr_data_o, sfr_rd_data_i, sfr_bit_addr_o;
  logic       sfr_we_o, sfr_bit_we_o, sfr_bit_val_o, sfr_bit_rd_i;
  logic [2:0] sfr_bit_idx_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  iram_core dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_mem [128];
  logic [7:0] m_sp;
  logic       m_err;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_we_i = 0; dir_we_i = 0; bit_op_i = 0; bit_val_i = 0;
    push_i = 0; pop_i = 0; sp_load_i = 0;
    reg_wr_data_i = 0; dir_wr_data_i = 0; push_data_i = 0; sp_load_val_i = 0;
  endtask

  function automatic logic new_bit(logic cur);
    case (bit_op_i)
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      2'd3: return bit_val_i;
      default: return cur;
    endcase
  endfunction

  // compare all outputs against the model, then advance one clock
  task automatic step(string tag);
    logic [7:0] nm [128];
    logic [7:0] tgt;
    logic [7:0] bb;
    logic push_eff, pop_eff;
    int eb;
    #2;
    chk(tag, "reg_rd", reg_rd_data_o, m_mem[{bank_sel_i, reg_rd_idx_i}]);
    chk(tag, "dir_rd", dir_rd_data_o,
        dir_addr_i < 128 ? m_mem[dir_addr_i[6:0]] : sfr_rd_data_i);
    bb = 8'h20 + {4'd0, bit_addr_i[6:3]};
    eb = bit_addr_i < 128 ? m_mem[bb[6:0]][bit_addr_i[2:0]] : sfr_bit_rd_i;
    chk(tag, "bit_rd", bit_rd_o, eb);
    chk(tag, "pop_data", pop_data_o, m_sp < 128 ? m_mem[m_sp[6:0]] : 0);
    chk(tag, "sp", sp_o, m_sp);
    chk(tag, "stk_err", stk_err_o, m_err);
    chk(tag, "sfr_we", sfr_we_o, dir_we_i && dir_addr_i >= 128);
    chk(tag, "sfr_bit_we", sfr_bit_we_o, bit_op_i != 0 && bit_addr_i >= 128);
    if (dir_we_i && dir_addr_i >= 128) begin
      chk(tag, "sfr_addr", sfr_addr_o, dir_addr_i);
      chk(tag, "sfr_wdata", sfr_wr_data_o, dir_wr_data_i);
    end
    if (bit_op_i != 0 && bit_addr_i >= 128) begin
      chk(tag, "sfr_bit_addr", sfr_bit_addr_o, bit_addr_i & 8'hF8);
      chk(tag, "sfr_bit_idx", sfr_bit_idx_o, bit_addr_i & 7);
      chk(tag, "sfr_bit_val", sfr_bit_val_o, new_bit(1'b0));
    end
    nm = m_mem;
    push_eff = push_i && !sp_load_i;
    pop_eff  = pop_i && !push_i && !sp_load_i;
    tgt = m_sp + 8'd1;
    if (bit_op_i != 0 && bit_addr_i < 128) nm[bb[6:0]][bit_addr_i[2:0]] = new_bit(1'b0);
    if (reg_we_i) nm[{bank_sel_i, reg_wr_idx_i}] = reg_wr_data_i;
    if (dir_we_i && dir_addr_i < 128) nm[dir_addr_i[6:0]] = dir_wr_data_i;
    if (push_eff && tgt < 128) nm[tgt[6:0]] = push_data_i;
    @(posedge clk_i);
    m_mem = nm;
    m_err = (push_eff && tgt >= 128) || (pop_eff && m_sp >= 128);
    if (sp_load_i) m_sp = sp_load_val_i;
    else if (push_eff) m_sp = tgt;
    else if (pop_eff) m_sp = m_sp - 8'd1;
    @(negedge clk_i);
    idle();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle();
    bank_sel_i = 0; reg_rd_idx_i = 0; reg_wr_idx_i = 0;
    dir_addr_i = 0; bit_addr_i = 0; sfr_rd_data_i = 8'h3C; sfr_bit_rd_i = 1;
    for (int i = 0; i < 128; i++) m_mem[i] = 0;
    m_sp = 8'h07; m_err = 0;
    repeat (3) @(negedge clk_i);
    // R1: reset values visible while reset is held and after release
    step("R1");
    rst_ni = 1;
    for (int a = 0; a < 128; a += 37) begin dir_addr_i = 8'(a); step("R1"); end

    // R2: register writes into each bank, read back through the bank window
    for (int b = 0; b < 4; b++) begin
      bank_sel_i = 2'(b);
      for (int r = 0; r < 8; r += 3) begin
        reg_we_i = 1; reg_wr_idx_i = 3'(r); reg_wr_data_i = 8'(16 * b + r + 1);
        step("R2");
        reg_rd_idx_i = 3'(r); step("R2");
      end
    end

    // R3: registers of inactive banks and general storage via direct address
    bank_sel_i = 0;
    dir_addr_i = 8'h13; step("R3");
    dir_addr_i = 8'h1B; dir_we_i = 1; dir_wr_data_i = 8'h5A; step("R3");
    bank_sel_i = 3; reg_rd_idx_i = 3; step("R3");
    dir_addr_i = 8'h7F; dir_we_i = 1; dir_wr_data_i = 8'hC3; step("R3");
    dir_addr_i = 8'h30; dir_we_i = 1; dir_wr_data_i = 8'h11; step("R3");
    dir_addr_i = 8'h7F; step("R3");

    // R4: bit window reads
    dir_addr_i = 8'h25; dir_we_i = 1; dir_wr_data_i = 8'hA5; step("R4");
    for (int b = 8'h28; b < 8'h30; b++) begin bit_addr_i = 8'(b); step("R4"); end
    dir_addr_i = 8'h2F; dir_we_i = 1; dir_wr_data_i = 8'h80; step("R4");
    bit_addr_i = 8'h7F; step("R4");

    // R5: set, clear, write; the rest of the byte must not move
    dir_addr_i = 8'h25;
    bit_addr_i = 8'h29; bit_op_i = 2; step("R5");
    bit_addr_i = 8'h2E; bit_op_i = 1; step("R5");
    bit_addr_i = 8'h2F; bit_op_i = 3; bit_val_i = 0; step("R5");
    bit_addr_i = 8'h28; bit_op_i = 3; bit_val_i = 0; step("R5");
    bit_addr_i = 8'h00; bit_op_i = 1; step("R5");
    dir_addr_i = 8'h20; step("R5");

    // R6: bit addresses in the upper half go to the peripheral port
    bit_addr_i = 8'h97; bit_op_i = 1; step("R6");
    bit_addr_i = 8'hE2; bit_op_i = 3; bit_val_i = 1; step("R6");
    bit_addr_i = 8'h80; bit_op_i = 2; sfr_bit_rd_i = 0; step("R6");
    dir_addr_i = 8'h20; bit_addr_i = 8'hFF; sfr_bit_rd_i = 1; step("R6");

    // R7: upper direct addresses never reach the array
    dir_addr_i = 8'h90; dir_we_i = 1; dir_wr_data_i = 8'h77; step("R7");
    dir_addr_i = 8'h10; step("R7");
    dir_addr_i = 8'hD0; sfr_rd_data_i = 8'h9E; step("R7");

    // R8: push three, pop three
    for (int k = 0; k < 3; k++) begin push_i = 1; push_data_i = 8'(8'hB0 + k); step("R8"); end
    dir_addr_i = 8'h0A; step("R8");
    for (int k = 0; k < 3; k++) begin pop_i = 1; step("R8"); end
    step("R8");

    // R9: load, simultaneous push and pop, load beats push
    sp_load_i = 1; sp_load_val_i = 8'h40; step("R9");
    push_i = 1; pop_i = 1; push_data_i = 8'h6D; step("R9");
    sp_load_i = 1; sp_load_val_i = 8'h50; push_i = 1; push_data_i = 8'hEE; step("R9");
    dir_addr_i = 8'h51; step("R9");
    step("R9");

    // R10: leaving internal RAM and wrapping
    sp_load_i = 1; sp_load_val_i = 8'h7E; step("R10");
    push_i = 1; push_data_i = 8'h42; step("R10");
    push_i = 1; push_data_i = 8'h43; step("R10");
    step("R10");
    sp_load_i = 1; sp_load_val_i = 8'hFF; step("R10");
    push_i = 1; push_data_i = 8'h99; step("R10");
    dir_addr_i = 8'h00; step("R10");
    sp_load_i = 1; sp_load_val_i = 8'h90; step("R10");
    pop_i = 1; step("R10");
    step("R10");
    sp_load_i = 1; sp_load_val_i = 8'h80; step("R10");
    pop_i = 1; step("R10");
    step("R10");

    // R11: same-byte collisions
    sp_load_i = 1; sp_load_val_i = 8'h2F; step("R11");
    push_i = 1; push_data_i = 8'h12; dir_addr_i = 8'h30; dir_we_i = 1; dir_wr_data_i = 8'h34;
    step("R11");
    dir_addr_i = 8'h30; step("R11");
    bank_sel_i = 2; dir_addr_i = 8'h14; dir_we_i = 1; dir_wr_data_i = 8'hAB;
    reg_we_i = 1; reg_wr_idx_i = 4; reg_wr_data_i = 8'hCD; step("R11");
    step("R11");
    dir_addr_i = 8'h26; reg_wr_idx_i = 6; bank_sel_i = 0;
    sp_load_i = 1; sp_load_val_i = 8'h25; step("R11");
    push_i = 1; push_data_i = 8'h0F; bit_addr_i = 8'h37; bit_op_i = 1; step("R11");
    bank_sel_i = 0; dir_addr_i = 8'h26; step("R11");
    bit_addr_i = 8'h31; bit_op_i = 2; dir_we_i = 1; dir_wr_data_i = 8'h02; step("R11");
    step("R11");
    summary();
  end
endmodule